// File: doc/BRIEF.md
# Inbound Message Frame Queue

This block takes whole messages arriving on a beat-oriented stream and stores each one in memory, one message per fixed 4096-byte slot of a circular ring. The ring starts at a software-programmed base address. Its length is a power of two, set by a logarithmic code in the mode register. Two hardware pointers mark the ring: the enqueue pointer is the slot the next message will fill, and the dequeue pointer is the oldest slot that software has not yet released. Memory writes leave through a simple valid/ready port, and the stream is stalled whenever memory is not ready.

Software reads the slot at the dequeue pointer, then sets the advance bit of the mode register to release that slot. A status register records a receive error (a message that ended with the error flag), a queue-full drop, and whether a message is waiting. All three flags are write-one-to-clear. The interrupt output follows the message-waiting flag. All mailboxes share the one queue.

Top module: `msg_frame_queue`

## Requirements
- R1: After a synchronous active-low reset, the mode, status, dequeue pointer and enqueue pointer registers all read 0, `irq` is 0, and `m_valid` and `s_ready` are 0.
- R2: A write to register address 2 loads both the dequeue and the enqueue pointer with the written value with its low 12 bits forced to 0, and this value becomes the ring base. Address 2 reads back the dequeue pointer and address 3 reads back the enqueue pointer.
- R3: While mode bit 0 (enable) is 0, `s_ready` and `m_valid` stay low. Writing 0 to the mode register (address 0) disables the unit.
- R4: Beat k of a stored message is presented on `m_addr` = enqueue pointer + 4·k with its data on `m_data`. While `m_ready` is low the beat is held and `s_ready` is low.
- R5: When the last beat of a message is accepted without error, the enqueue pointer moves on by 4096. If the slot index, (pointer − base)/4096, was the last of the ring, it wraps to the base. The ring has 2^(code+2) entries, where code is mode bits 15:12; code 15 means 2 entries and codes 10 to 14 mean 2048.
- R6: Writing the mode register with bit 1 set advances the dequeue pointer by one slot, with the same wrap rule, if the pointers differ. If they are equal, the command is ignored. Bit 1 always reads back as 0.
- R7: If, at the first beat of a message, advancing the enqueue pointer would make it equal to the dequeue pointer, the whole message is accepted and dropped with no memory write, the enqueue pointer stays where it is, and status bit 4 is set.
- R8: A message whose last beat carries `s_err` is not committed, so the enqueue pointer stays where it is, and status bit 7 is set.
- R9: Status (address 1) bit 0 is set whenever the pointers differ, even right after software has cleared it. Writing 1 to bit 7, 4 or 0 clears that bit, so writing 0x91 clears all three when the queue is empty.
- R10: `irq` equals status bit 0.
- R11: Beats beyond the 1024th beat of a message, which do not fit in one slot, are accepted but not written to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 status, 2 dequeue/base, 3 enqueue |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted |
| s_data | input | DATA_W | Stream beat data |
| s_last | input | 1 | Final beat of a message |
| s_err | input | 1 | Receive error, sampled with the final beat |
| m_valid | output | 1 | Memory write request |
| m_ready | input | 1 | Memory write accepted |
| m_addr | output | ADDR_W | Memory byte address |
| m_data | output | DATA_W | Memory write data |
| irq | output | 1 | Message waiting interrupt |

## Verification
The bench drives the ring until it is exactly full and checks that the next message is dropped whole. A design that tested fullness against the wrong pointer would overwrite the unread slot, and one that decided per beat would store part of the message. It checks wrap-around on both pointers, including the 2-entry code. An off-by-one in the last-index compare would send a pointer past the ring end. It also checks that an advance command on an empty ring does nothing, that clearing the waiting flag while messages remain does not stick, that an erroring message is written but never committed, and that a 1030-beat message writes exactly 1024 beats and does not spill into the next slot.

// File: rtl/mfq_pkg.sv
// Shared constants for the inbound message frame queue.
// Assumes a fixed 4096-byte slot and at most 2048 ring entries.
package mfq_pkg;
    localparam int SLOT_LG = 12;
    localparam int MAX_LG  = 11;

    localparam logic [1:0] REG_MODE = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_DEQ  = 2'd2;
    localparam logic [1:0] REG_ENQ  = 2'd3;

    localparam int MODE_EN  = 0;
    localparam int MODE_INC = 1;
    localparam int MODE_SZ  = 12;

    localparam int ST_Q    = 0;
    localparam int ST_FULL = 4;
    localparam int ST_ERR  = 7;

    // Ring size exponent from the 4-bit size code.
    function automatic logic [3:0] ring_lg(input logic [3:0] code);
        if (code == 4'hF)
            return 4'd1;
        else if (code > 4'd9)
            return 4'(MAX_LG);
        else
            return code + 4'd2;
    endfunction
endpackage

// File: rtl/mfq_ring_ptr.sv
// One ring pointer: loads from the base, advances one slot with wrap.
// Assumes base is slot aligned and the pointer lies inside the ring.
module mfq_ring_ptr
    import mfq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic [ADDR_W-1:0] base,
    input  logic [3:0]        size_code,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] nxt
);
    localparam logic [ADDR_W-1:0] SLOT_STEP = ADDR_W'(1) << SLOT_LG;

    logic [MAX_LG-1:0] idx;
    logic [MAX_LG-1:0] last_idx;
    logic [3:0]        lg;

    // Slot index, last index of the ring and the advanced pointer value.
    always_comb begin
        lg       = ring_lg(size_code);
        idx      = MAX_LG'((ptr - base) >> SLOT_LG);
        last_idx = {MAX_LG{1'b1}} >> (4'(MAX_LG) - lg);
        nxt      = (idx == last_idx) ? base : ptr + SLOT_STEP;
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (adv)
            ptr <= nxt;
    end

    // R5
    adv_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (ptr != $past(ptr)));
endmodule

// File: rtl/mfq_writer.sv
// Moves stream beats into the current slot and reports message outcomes.
// Assumes the full decision at a message's first beat holds for all its beats.
module mfq_writer
    import mfq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              full,
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    input  logic              s_err,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_data,
    output logic              commit,
    output logic              err_evt,
    output logic              full_evt
);
    localparam int BEAT_LG = $clog2(DATA_W / 8);
    localparam int BEATS   = 1 << (SLOT_LG - BEAT_LG);
    localparam int CNT_W   = SLOT_LG - BEAT_LG + 1;

    logic             in_msg;
    logic             drop_q;
    logic [CNT_W-1:0] cnt;
    logic             drop_now;
    logic             over;
    logic             fire;

    // Beat routing, handshakes and end-of-message events.
    always_comb begin
        drop_now = in_msg ? drop_q : full;
        over     = (cnt >= CNT_W'(BEATS));
        m_valid  = enable && s_valid && !drop_now && !over;
        s_ready  = enable && (drop_now || over || m_ready);
        m_addr   = slot_addr + (ADDR_W'(cnt) << BEAT_LG);
        m_data   = s_data;
        fire     = s_valid && s_ready;
        commit   = fire && s_last && !drop_now && !s_err;
        err_evt  = fire && s_last && s_err;
        full_evt = fire && !in_msg && full;
    end

    // Message state: inside a message, drop decision, beat count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_msg <= 1'b0;
            drop_q <= 1'b0;
            cnt    <= '0;
        end else if (fire) begin
            if (s_last) begin
                in_msg <= 1'b0;
                drop_q <= 1'b0;
                cnt    <= '0;
            end else begin
                in_msg <= 1'b1;
                drop_q <= drop_now;
                cnt    <= over ? cnt : cnt + 1'b1;
            end
        end
    end

    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!m_valid && !s_ready));
endmodule

// File: rtl/msg_frame_queue.sv
// Inbound message frame queue: one message per 4096-byte ring slot,
// mode/status/pointer registers and a message-waiting interrupt.
// Assumes software writes the base before enabling the unit.
module msg_frame_queue
    import mfq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    input  logic              s_err,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_data,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << SLOT_LG) - 1'b1);

    logic              mode_en;
    logic [3:0]        size_code;
    logic [ADDR_W-1:0] base;
    logic              st_err, st_full, st_q;
    logic [ADDR_W-1:0] deq_ptr, deq_nxt, enq_ptr, enq_nxt;
    logic              base_ld, mode_wr, stat_wr, deq_adv;
    logic              commit, err_evt, full_evt, full;
    logic [ADDR_W-1:0] base_val;

    // Register write decode and queue conditions.
    always_comb begin
        base_ld  = reg_we && (reg_addr == REG_DEQ);
        mode_wr  = reg_we && (reg_addr == REG_MODE);
        stat_wr  = reg_we && (reg_addr == REG_STAT);
        base_val = ADDR_W'(reg_wdata) & ALIGN_MASK;
        deq_adv  = mode_wr && reg_wdata[MODE_INC] && (deq_ptr != enq_ptr);
        full     = (enq_nxt == deq_ptr);
    end

    // Mode fields and ring base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_en   <= 1'b0;
            size_code <= '0;
            base      <= '0;
        end else begin
            if (mode_wr) begin
                mode_en   <= reg_wdata[MODE_EN];
                size_code <= reg_wdata[MODE_SZ +: 4];
            end
            if (base_ld)
                base <= base_val;
        end
    end

    // Status flags: events set, write-one clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_err  <= 1'b0;
            st_full <= 1'b0;
            st_q    <= 1'b0;
        end else begin
            st_err  <= (st_err  && !(stat_wr && reg_wdata[ST_ERR]))  || err_evt;
            st_full <= (st_full && !(stat_wr && reg_wdata[ST_FULL])) || full_evt;
            st_q    <= (st_q    && !(stat_wr && reg_wdata[ST_Q]))    || (deq_ptr != enq_ptr);
        end
    end

    // Register read mux.
    always_comb begin
        case (reg_addr)
            REG_MODE: reg_rdata = {16'd0, size_code, 11'd0, mode_en};
            REG_STAT: reg_rdata = {24'd0, st_err, 2'd0, st_full, 3'd0, st_q};
            REG_DEQ:  reg_rdata = 32'(deq_ptr);
            default:  reg_rdata = 32'(enq_ptr);
        endcase
    end

    assign irq = st_q;

    mfq_ring_ptr #(.ADDR_W(ADDR_W)) u_deq (
        .clk(clk), .rst_n(rst_n), .load(base_ld), .load_val(base_val),
        .base(base), .size_code(size_code), .adv(deq_adv),
        .ptr(deq_ptr), .nxt(deq_nxt)
    );

    mfq_ring_ptr #(.ADDR_W(ADDR_W)) u_enq (
        .clk(clk), .rst_n(rst_n), .load(base_ld), .load_val(base_val),
        .base(base), .size_code(size_code), .adv(commit),
        .ptr(enq_ptr), .nxt(enq_nxt)
    );

    mfq_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .enable(mode_en), .full(full),
        .slot_addr(enq_ptr), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_last(s_last), .s_err(s_err),
        .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data),
        .commit(commit), .err_evt(err_evt), .full_evt(full_evt)
    );

    // R9
    q_follows_ptrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_ptr != enq_ptr) |=> st_q);
    // R8
    err_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> st_err);
    // R7
    full_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_evt |=> st_full);
    // R7
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(base_ld) && (enq_ptr != $past(enq_ptr))) |-> (enq_ptr != deq_ptr));
endmodule

// File: tb/msg_frame_queue_tb.sv
module msg_frame_queue_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0001_0000;

    typedef struct packed {
        logic [1:0]  op;     // 0 send, 1 advance dequeue, 2 clear status
        logic [11:0] beats;
        logic        err;
        logic        wr;     // message beats reach memory
        logic [1:0]  enq_i;
        logic [1:0]  deq_i;
        logic [7:0]  stat;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{2'd0, 12'd2, 1'b0, 1'b1, 2'd1, 2'd0, 8'h01},
        '{2'd0, 12'd1, 1'b1, 1'b1, 2'd1, 2'd0, 8'h81},
        '{2'd0, 12'd3, 1'b0, 1'b1, 2'd2, 2'd0, 8'h81},
        '{2'd0, 12'd1, 1'b0, 1'b1, 2'd3, 2'd0, 8'h81},
        '{2'd0, 12'd2, 1'b0, 1'b0, 2'd3, 2'd0, 8'h91},
        '{2'd1, 12'd0, 1'b0, 1'b0, 2'd3, 2'd1, 8'h91},
        '{2'd0, 12'd1, 1'b0, 1'b1, 2'd0, 2'd1, 8'h91},
        '{2'd1, 12'd0, 1'b0, 1'b0, 2'd0, 2'd2, 8'h91},
        '{2'd1, 12'd0, 1'b0, 1'b0, 2'd0, 2'd3, 8'h91},
        '{2'd1, 12'd0, 1'b0, 1'b0, 2'd0, 2'd0, 8'h91},
        '{2'd1, 12'd0, 1'b0, 1'b0, 2'd0, 2'd0, 8'h91},
        '{2'd2, 12'd0, 1'b0, 1'b0, 2'd0, 2'd0, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        s_valid = 1'b0, s_last = 1'b0, s_err = 1'b0;
    logic        s_ready;
    logic [31:0] s_data = '0;
    logic        m_valid;
    logic        m_ready = 1'b1;
    logic [31:0] m_addr, m_data;
    logic        irq;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    msg_frame_queue u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_valid(s_valid),
        .s_ready(s_ready), .s_data(s_data), .s_last(s_last), .s_err(s_err),
        .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data),
        .irq(irq)
    );

    always @(posedge clk) if (m_valid && m_ready) wr_cnt <= wr_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    // Sends one message; checks address and data of the first two beats when expected.
    task automatic send_msg(input int beats, input bit err, input bit expw, input logic [31:0] slot);
        @(negedge clk);
        for (int k = 0; k < beats; k++) begin
            s_valid = 1'b1;
            s_data  = 32'hD000_0000 + k;
            s_last  = (k == beats - 1);
            s_err   = err && (k == beats - 1);
            #1;
            while (!s_ready) begin
                @(negedge clk);
                #1;
            end
            if (expw && k < 2) begin
                chk("R4 m_addr", m_addr, slot + 32'(4 * k));
                chk("R4 m_data", m_data, 32'hD000_0000 + k);
            end
            @(posedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0; s_err = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [1:0]  prev_enq;
        int w0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd0, rd); chk("R1 mode", rd, 32'h0);
        reg_read(2'd1, rd); chk("R1 stat", rd, 32'h0);
        reg_read(2'd2, rd); chk("R1 deq", rd, 32'h0);
        reg_read(2'd3, rd); chk("R1 enq", rd, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        chk("R1 m_valid", {31'd0, m_valid}, 32'h0);

        // R3 disabled unit ignores the stream
        s_valid = 1'b1; s_last = 1'b1; #1;
        chk("R3 s_ready off", {31'd0, s_ready}, 32'h0);
        chk("R3 m_valid off", {31'd0, m_valid}, 32'h0);
        s_valid = 1'b0; s_last = 1'b0;

        // Table: 4-entry ring (code 0)
        reg_write(2'd2, BASE);
        reg_write(2'd0, 32'h0000_0001);
        prev_enq = 2'd0;
        for (int i = 0; i < 12; i++) begin
            w0 = wr_cnt;
            case (VECS[i].op)
                2'd0: send_msg(int'(VECS[i].beats), VECS[i].err, VECS[i].wr,
                               BASE + 32'(prev_enq) * 32'h1000);
                2'd1: reg_write(2'd0, 32'h0000_0003);
                default: reg_write(2'd1, 32'h0000_0091);
            endcase
            settle();
            chk("R7 writes", 32'(wr_cnt - w0),
                VECS[i].wr ? 32'(VECS[i].beats) : 32'h0);
            reg_read(2'd3, rd); chk("R5 enq", rd, BASE + 32'(VECS[i].enq_i) * 32'h1000);
            reg_read(2'd2, rd); chk("R6 deq", rd, BASE + 32'(VECS[i].deq_i) * 32'h1000);
            reg_read(2'd1, rd); chk("R9 stat", rd, {24'd0, VECS[i].stat});
            prev_enq = VECS[i].enq_i;
        end
        chk("R10 irq empty", {31'd0, irq}, 32'h0);

        // R6 advance bit reads back as 0
        reg_read(2'd0, rd); chk("R6 mode readback", rd, 32'h0000_0001);

        // R9 clearing while a message waits does not stick; R10 irq follows
        send_msg(1, 1'b0, 1'b1, BASE);
        settle();
        reg_write(2'd1, 32'h0000_0001);
        settle();
        reg_read(2'd1, rd); chk("R9 q resets", rd & 32'h1, 32'h1);
        chk("R10 irq set", {31'd0, irq}, 32'h1);

        // R2 base write aligns and loads both pointers
        reg_write(2'd2, 32'h0002_0ABC);
        reg_read(2'd2, rd); chk("R2 deq", rd, 32'h0002_0000);
        reg_read(2'd3, rd); chk("R2 enq", rd, 32'h0002_0000);

        // R5 code 15 gives a 2-entry ring
        reg_write(2'd0, 32'h0000_F001);
        reg_write(2'd2, 32'h0003_0000);
        send_msg(1, 1'b0, 1'b1, 32'h0003_0000);
        settle();
        reg_read(2'd3, rd); chk("R5 two-entry step", rd, 32'h0003_1000);
        reg_write(2'd0, 32'h0000_F003);
        reg_read(2'd2, rd); chk("R6 deq step", rd, 32'h0003_1000);
        send_msg(1, 1'b0, 1'b1, 32'h0003_1000);
        settle();
        reg_read(2'd3, rd); chk("R5 two-entry wrap", rd, 32'h0003_0000);

        // R4 memory stall holds the beat
        reg_write(2'd2, 32'h0004_0000);
        @(negedge clk);
        m_ready = 1'b0; s_valid = 1'b1; s_last = 1'b1; s_data = 32'hCAFE_0001;
        #1;
        chk("R4 stall s_ready", {31'd0, s_ready}, 32'h0);
        chk("R4 stall m_valid", {31'd0, m_valid}, 32'h1);
        repeat (3) @(negedge clk);
        chk("R4 held data", m_data, 32'hCAFE_0001);
        reg_read(2'd3, rd); chk("R4 no commit in stall", rd, 32'h0004_0000);
        @(negedge clk);
        m_ready = 1'b1;
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        settle();
        reg_read(2'd3, rd); chk("R4 commit after stall", rd, 32'h0004_1000);

        // R11 oversize message writes one slot only
        reg_write(2'd2, 32'h0005_0000);
        w0 = wr_cnt;
        send_msg(1030, 1'b0, 1'b1, 32'h0005_0000);
        settle();
        chk("R11 beats written", 32'(wr_cnt - w0), 32'd1024);
        reg_read(2'd3, rd); chk("R11 enq", rd, 32'h0005_1000);

        // R3 writing 0 disables
        reg_write(2'd0, 32'h0);
        reg_read(2'd0, rd); chk("R3 mode zero", rd, 32'h0);
        @(negedge clk);
        s_valid = 1'b1; #1;
        chk("R3 s_ready after disable", {31'd0, s_ready}, 32'h0);
        s_valid = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule